// File: doc/BRIEF.md
# Five-Function Integer ALU with Status Flags

The block is a purely combinational 32-bit integer unit for the execute stage of a simple processor pipeline. A 3-bit function code picks one of five operations on two operand words: bitwise AND, bitwise OR, addition, subtraction and a signed less-than test. It also returns three status flags. The zero flag is used for equal/not-equal branch decisions. The overflow flag reports signed overflow. The carry-out flag reports the carry leaving the top bit of the adder.

Subtraction and the less-than test use the same adder as addition. The second operand is inverted and the carry into bit 0 is forced to one. For the less-than test, the sign of the difference is corrected by the overflow condition, and the corrected value is placed in bit 0 of an otherwise zero word. The adder is a two-level carry-lookahead structure made of 4-bit groups. The output is settled within the same cycle as the inputs, with no clock inside the block.

Top module: `alu32`

## Requirements
- R1: Function code 000 returns the bitwise AND of A and B.
- R2: Function code 001 returns the bitwise OR of A and B.
- R3: Function code 010 returns A plus B modulo 2^32. The carry-out flag equals bit 32 of the unsigned 33-bit sum, and that bit never appears in the result.
- R4: Function code 110 returns A minus B modulo 2^32. The carry-out flag equals bit 32 of A + ~B + 1, which is 1 when no borrow occurs.
- R5: For codes 010 and 110, the overflow flag is 1 exactly when the signed result is wrong. For addition, that means operands of equal sign give a result of the other sign. For subtraction, a non-negative A minus a negative B gives a negative result, or a negative A minus a non-negative B gives a non-negative result.
- R6: Function code 111 returns 1 in bit 0 when A is less than B as signed two's-complement numbers and 0 otherwise, with bits 31..1 always 0. This holds even when A minus B overflows.
- R7: For codes 000, 001, 010, 110 and 111, the zero flag is 1 exactly when all 32 result bits are 0.
- R8: For codes 000 and 001, the overflow and carry-out flags are both 0.
- R9: Codes 011, 100 and 101 are undefined. They return a result of 0 with zero, overflow and carry-out all 0.
- R10: For code 111, the overflow and carry-out flags report the subtraction A minus B exactly as under code 110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand (minuend for subtraction and compare) |
| opB | input | 32 | Second operand (subtrahend for subtraction and compare) |
| funcSel | input | 3 | Function code: 000 AND, 001 OR, 010 add, 110 subtract, 111 signed less-than |
| result | output | 32 | Result word of the selected function |
| zeroFlag | output | 1 | Result is all zeros (defined codes only) |
| overflowFlag | output | 1 | Signed overflow of the add or subtract |
| carryOut | output | 1 | Carry out of the most significant adder bit |

## Verification
The interesting coincidence is a less-than test whose internal subtraction overflows. In that cycle, the sign bit of the difference and the overflow detection interact, and the result bit must be the inverted sign. The bench provokes it with operand pairs at opposite ends of the signed range, such as 0x80000000 against 1 and 0x7FFFFFFF against 0xFFFFFFFF. It then judges bit 0 against the true signed order of the operands and, at the same moment, the overflow flag against the subtraction rule. Zero-result sums that also produce a carry and an overflow, such as 0x80000000 plus itself, are judged the same way across all three flags at once.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  localparam int DataW  = 32;
  localparam int GroupW = 4;
  localparam int FuncW  = 3;

  localparam logic [FuncW-1:0] FuncAnd = 3'b000;
  localparam logic [FuncW-1:0] FuncOr  = 3'b001;
  localparam logic [FuncW-1:0] FuncAdd = 3'b010;
  localparam logic [FuncW-1:0] FuncSub = 3'b110;
  localparam logic [FuncW-1:0] FuncSlt = 3'b111;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic known;       // function code is defined
    logic bInvert;     // feed ~B into the adder
    logic carryIn;     // carry into bit 0
    logic selAnd;      // result from AND plane
    logic selOr;       // result from OR plane
    logic selSum;      // result from adder
    logic selLess;     // result is the corrected less-than bit
    logic arithFlags;  // overflow / carry-out are meaningful
  } aluCtlT;

endpackage

// File: rtl/alu32_cla.sv
module alu32_cla #(
  parameter int WIDTH   = 32,
  parameter int GROUP_W = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cIn,
  output logic [WIDTH-1:0] sum,
  output logic             cOut,
  output logic             cIntoMsb
);

  localparam int NumGroups = WIDTH / GROUP_W;

  logic [WIDTH-1:0]     bitGen;
  logic [WIDTH-1:0]     bitProp;
  logic [WIDTH-1:0]     bitCarry;
  logic [NumGroups-1:0] grpGen;
  logic [NumGroups-1:0] grpProp;
  logic [NumGroups:0]   grpCarry;

  assign bitGen  = x & y;
  assign bitProp = x | y;

  // Group generate / propagate terms
  genvar k;
  generate
    for (k = 0; k < NumGroups; k++) begin : gGroup
      logic [GROUP_W-1:0] gG;
      logic [GROUP_W-1:0] gP;
      logic [GROUP_W-1:0] cLocal;

      assign gG = bitGen[k*GROUP_W +: GROUP_W];
      assign gP = bitProp[k*GROUP_W +: GROUP_W];

      always_comb begin
        logic acc;
        acc = 1'b0;
        for (int j = 0; j < GROUP_W; j++) begin
          acc = gG[j] | (gP[j] & acc);
        end
        grpGen[k]  = acc;
        grpProp[k] = &gP;
      end

      // Flattened lookahead of each bit carry from the group carry-in
      always_comb begin
        for (int i = 0; i < GROUP_W; i++) begin
          logic termAcc;
          logic runP;
          termAcc = 1'b0;
          runP    = 1'b1;
          for (int j = GROUP_W - 1; j >= 0; j--) begin
            if (j < i) begin
              termAcc = termAcc | (runP & gG[j]);
              runP    = runP & gP[j];
            end
          end
          cLocal[i] = termAcc | (runP & grpCarry[k]);
        end
      end

      assign bitCarry[k*GROUP_W +: GROUP_W] = cLocal;
    end
  endgenerate

  // Second-level lookahead across groups
  always_comb begin
    grpCarry[0] = cIn;
    for (int m = 1; m <= NumGroups; m++) begin
      logic termAcc;
      logic runP;
      termAcc = 1'b0;
      runP    = 1'b1;
      for (int j = NumGroups - 1; j >= 0; j--) begin
        if (j < m) begin
          termAcc = termAcc | (runP & grpGen[j]);
          runP    = runP & grpProp[j];
        end
      end
      grpCarry[m] = termAcc | (runP & cIn);
    end
  end

  assign sum      = x ^ y ^ bitCarry;
  assign cOut     = grpCarry[NumGroups];
  assign cIntoMsb = bitCarry[WIDTH-1];

endmodule

// File: rtl/alu32_ctrl.sv
module alu32_ctrl
  import alu32_pkg::*;
(
  input  logic [FuncW-1:0] funcSel,
  output aluCtlT           ctl
);

  always_comb begin
    ctl = '0;
    unique case (funcSel)
      FuncAnd: begin
        ctl.known  = 1'b1;
        ctl.selAnd = 1'b1;
      end
      FuncOr: begin
        ctl.known = 1'b1;
        ctl.selOr = 1'b1;
      end
      FuncAdd: begin
        ctl.known      = 1'b1;
        ctl.selSum     = 1'b1;
        ctl.arithFlags = 1'b1;
      end
      FuncSub: begin
        ctl.known      = 1'b1;
        ctl.bInvert    = funcSel[2];
        ctl.carryIn    = funcSel[2];
        ctl.selSum     = 1'b1;
        ctl.arithFlags = 1'b1;
      end
      FuncSlt: begin
        ctl.known      = 1'b1;
        ctl.bInvert    = funcSel[2];
        ctl.carryIn    = funcSel[2];
        ctl.selLess    = 1'b1;
        ctl.arithFlags = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/alu32_dp.sv
module alu32_dp
  import alu32_pkg::*;
#(
  parameter int WIDTH   = DataW,
  parameter int GROUP_W = GroupW
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtlT           ctl,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             overflowFlag,
  output logic             carryOut
);

  logic [WIDTH-1:0] bFeed;
  logic [WIDTH-1:0] sumVal;
  logic             addCout;
  logic             addCMsb;
  logic             rawOvf;
  logic             lessBit;

  assign bFeed = ctl.bInvert ? ~opB : opB;

  alu32_cla #(
    .WIDTH  (WIDTH),
    .GROUP_W(GROUP_W)
  ) uAdder (
    .x       (opA),
    .y       (bFeed),
    .cIn     (ctl.carryIn),
    .sum     (sumVal),
    .cOut    (addCout),
    .cIntoMsb(addCMsb)
  );

  // Signed overflow: carry into and out of the sign position disagree
  assign rawOvf  = addCout ^ addCMsb;
  // Sign of the difference, corrected when it overflowed
  assign lessBit = sumVal[WIDTH-1] ^ rawOvf;

  always_comb begin
    result = '0;
    if (ctl.selAnd)  result = opA & opB;
    if (ctl.selOr)   result = opA | opB;
    if (ctl.selSum)  result = sumVal;
    if (ctl.selLess) result = {{(WIDTH-1){1'b0}}, lessBit};
  end

  assign zeroFlag     = ctl.known & ~(|result);
  assign overflowFlag = ctl.arithFlags & rawOvf;
  assign carryOut     = ctl.arithFlags & addCout;

endmodule

// File: rtl/alu32.sv
module alu32
  import alu32_pkg::*;
#(
  parameter int WIDTH   = DataW,
  parameter int GROUP_W = GroupW
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [FuncW-1:0] funcSel,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             overflowFlag,
  output logic             carryOut
);

  aluCtlT ctl;

  alu32_ctrl uCtrl (
    .funcSel(funcSel),
    .ctl    (ctl)
  );

  alu32_dp #(
    .WIDTH  (WIDTH),
    .GROUP_W(GROUP_W)
  ) uDp (
    .opA         (opA),
    .opB         (opB),
    .ctl         (ctl),
    .result      (result),
    .zeroFlag    (zeroFlag),
    .overflowFlag(overflowFlag),
    .carryOut    (carryOut)
  );

endmodule

// File: rtl/alu32_checker.sv
module alu32_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       funcSel,
  input logic [WIDTH-1:0] result,
  input logic             zeroFlag,
  input logic             overflowFlag,
  input logic             carryOut
);

  logic [WIDTH:0] wideSum;
  logic [WIDTH:0] wideDiff;
  logic           definedCode;

  assign wideSum     = {1'b0, opA} + {1'b0, opB};
  assign wideDiff    = {1'b0, opA} + {1'b0, ~opB} + {{WIDTH{1'b0}}, 1'b1};
  assign definedCode = (funcSel == 3'b000) || (funcSel == 3'b001) ||
                       (funcSel == 3'b010) || (funcSel == 3'b110) ||
                       (funcSel == 3'b111);

  always_comb begin
    if (funcSel == 3'b010) begin
      // R3
      add_carry_chk: assert (carryOut == wideSum[WIDTH]);
      // R5
      add_overflow_chk: assert (overflowFlag ==
        ((opA[WIDTH-1] == opB[WIDTH-1]) && (result[WIDTH-1] != opA[WIDTH-1])));
    end
    if (funcSel == 3'b110) begin
      // R4
      sub_carry_chk: assert (carryOut == wideDiff[WIDTH]);
      // R5
      sub_overflow_chk: assert (overflowFlag ==
        ((opA[WIDTH-1] != opB[WIDTH-1]) && (result[WIDTH-1] != opA[WIDTH-1])));
    end
    if (funcSel == 3'b111) begin
      // R6
      less_result_chk: assert (result ==
        {{(WIDTH-1){1'b0}}, ($signed(opA) < $signed(opB))});
      // R10
      less_carry_chk: assert (carryOut == wideDiff[WIDTH]);
    end
    if (definedCode) begin
      // R7
      zero_flag_chk: assert (zeroFlag == (result == '0));
    end
    if (funcSel == 3'b000 || funcSel == 3'b001) begin
      // R8
      logic_flags_chk: assert (!overflowFlag && !carryOut);
    end
    if (!definedCode) begin
      // R9
      undefined_code_chk: assert (result == '0 && !zeroFlag && !overflowFlag && !carryOut);
    end
  end

endmodule

bind alu32 alu32_checker #(.WIDTH(WIDTH)) uChecker (
  .opA         (opA),
  .opB         (opB),
  .funcSel     (funcSel),
  .result      (result),
  .zeroFlag    (zeroFlag),
  .overflowFlag(overflowFlag),
  .carryOut    (carryOut)
);

// File: tb/alu32_test.sv
module alu32_test;

  localparam int CLK_PERIOD = 10;
  localparam int NumVec     = 18;
  localparam int SweepN     = 48;

  // {funcSel, A, B, result, zero, overflow, carry}
  localparam logic [101:0] VECS [NumVec] = '{
    {3'b000, 32'hF0F0F0F0, 32'h0FF00FF0, 32'h00F000F0, 1'b0, 1'b0, 1'b0},
    {3'b000, 32'h12345678, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 1'b0},
    {3'b001, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0},
    {3'b001, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 1'b0},
    {3'b010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1, 1'b0},
    {3'b010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0, 1'b1},
    {3'b010, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1, 1'b1},
    {3'b010, 32'h0000FFFF, 32'h00000001, 32'h00010000, 1'b0, 1'b0, 1'b0},
    {3'b110, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 1'b0, 1'b0, 1'b0},
    {3'b110, 32'h00000007, 32'h00000005, 32'h00000002, 1'b0, 1'b0, 1'b1},
    {3'b110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b1, 1'b1},
    {3'b110, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 1'b0, 1'b1, 1'b0},
    {3'b111, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0, 1'b0, 1'b1},
    {3'b111, 32'h80000000, 32'h00000001, 32'h00000001, 1'b0, 1'b1, 1'b1},
    {3'b111, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b1, 1'b0},
    {3'b111, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0, 1'b1},
    {3'b011, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b0, 1'b0},
    {3'b100, 32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 1'b0}
  };

  logic        clk;
  logic        rstN;
  logic [31:0] opA;
  logic [31:0] opB;
  logic [2:0]  funcSel;
  logic [31:0] result;
  logic        zeroFlag;
  logic        overflowFlag;
  logic        carryOut;

  int  checkCount;
  int  failCount;
  bit  finished;

  alu32 uut (
    .opA         (opA),
    .opB         (opB),
    .funcSel     (funcSel),
    .result      (result),
    .zeroFlag    (zeroFlag),
    .overflowFlag(overflowFlag),
    .carryOut    (carryOut)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic string reqTag(input logic [2:0] f);
    case (f)
      3'b000:  return "R1/R7/R8";
      3'b001:  return "R2/R7/R8";
      3'b010:  return "R3/R5/R7";
      3'b110:  return "R4/R5/R7";
      3'b111:  return "R6/R7/R10";
      default: return "R9";
    endcase
  endfunction

  // Reference built from the requirement text: {result, zero, ovf, carry}
  function automatic logic [34:0] refModel(input logic [2:0] f,
                                           input logic [31:0] a,
                                           input logic [31:0] b);
    logic [32:0] s;
    logic [32:0] d;
    logic [31:0] r;
    logic        v;
    logic        c;
    logic        ok;
    s  = {1'b0, a} + {1'b0, b};
    d  = {1'b0, a} + {1'b0, ~b} + 33'd1;
    r  = '0;
    v  = 1'b0;
    c  = 1'b0;
    ok = 1'b1;
    case (f)
      3'b000: r = a & b;
      3'b001: r = a | b;
      3'b010: begin
        r = s[31:0];
        c = s[32];
        v = (a[31] == b[31]) && (r[31] != a[31]);
      end
      3'b110: begin
        r = d[31:0];
        c = d[32];
        v = (a[31] != b[31]) && (r[31] != a[31]);
      end
      3'b111: begin
        r = {31'b0, ($signed(a) < $signed(b))};
        c = d[32];
        v = (a[31] != b[31]) && (d[31] != a[31]);
      end
      default: ok = 1'b0;
    endcase
    return {r, ok && (r == 32'h0), v, c};
  endfunction

  task automatic applyCheck(input logic [2:0] f, input logic [31:0] a,
                            input logic [31:0] b, input logic [34:0] exp);
    @(posedge clk);
    funcSel = f;
    opA     = a;
    opB     = b;
    @(negedge clk);
    checkCount++;
    if ({result, zeroFlag, overflowFlag, carryOut} !== exp) begin
      failCount++;
      $display("FAIL %s func=%b a=%h b=%h actual res=%h z=%b v=%b c=%b expected res=%h z=%b v=%b c=%b",
               reqTag(f), f, a, b, result, zeroFlag, overflowFlag, carryOut,
               exp[34:3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checkCount, failCount);
      $finish;
    end
  endtask

  initial begin
    logic [31:0] lfsr;
    checkCount = 0;
    failCount  = 0;
    finished   = 1'b0;
    rstN       = 1'b0;
    funcSel    = 3'b000;
    opA        = '0;
    opB        = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // Idle state after reset: AND of zeros gives zero result, zero flag set (R1, R7)
    @(negedge clk);
    checkCount++;
    if ({result, zeroFlag, overflowFlag, carryOut} !== {32'h0, 1'b1, 1'b0, 1'b0}) begin
      failCount++;
      $display("FAIL R7 idle actual res=%h z=%b v=%b c=%b expected res=00000000 z=1 v=0 c=0",
               result, zeroFlag, overflowFlag, carryOut);
    end

    // Table walk
    for (int i = 0; i < NumVec; i++) begin
      applyCheck(VECS[i][101:99], VECS[i][98:67], VECS[i][66:35], VECS[i][34:0]);
    end

    // Remaining undefined code with nonzero operands (R9)
    applyCheck(3'b101, 32'hDEADBEEF, 32'h01234567, {32'h0, 1'b0, 1'b0, 1'b0});

    // Signed compare across the overflow boundary (R6)
    applyCheck(3'b111, 32'h80000000, 32'h7FFFFFFF, {32'h1, 1'b0, 1'b1, 1'b1});
    applyCheck(3'b111, 32'h7FFFFFFF, 32'h80000000, {32'h0, 1'b1, 1'b1, 1'b0});

    // Pseudo-random sweep of every code against the reference
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < SweepN; n++) begin
      logic [31:0] a;
      logic [31:0] b;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      a = lfsr;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      b = (n % 6 == 0) ? a : lfsr;
      for (int f = 0; f < 8; f++) begin
        applyCheck(3'(f), a, b, refModel(3'(f), a, b));
      end
    end

    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failCount++;
    $display("FAIL watchdog expired actual running expected finished");
    finishRun();
  end

endmodule